// File: doc/BRIEF.md
# Multi-Port Register File with Hardwired Constants

This block is the architectural register file of a wide-issue processor core: 128 entries of 32 bits, four combinational read ports and two synchronous write ports, so that several operations can fetch operands and retire results in the same clock. Two entries are not storage at all. Entry 0 is wired to integer zero, which doubles as boolean false and as single-precision +0.0. Entry 1 is wired to integer one, which doubles as boolean true. Neither can ever be changed.

Entries 2 through 127 are ordinary flops with no role assigned by hardware. A write port that targets entry 0 or 1 has its write discarded and raises its own error flag in that same cycle, so a faulty instruction stream is reported without corrupting the constants. When both write ports aim at the same entry in one cycle, port 1 takes precedence. A read of an entry that is being written in the current cycle sees the incoming data through a bypass, so consumers do not wait a cycle for the flop. An active-low asynchronous reset clears all storage entries to zero.

Top module: `rf_const_regfile`

## Requirements
- R1: Entries 2..127 each hold 32 bits; a value written at a clock edge is returned on any read port afterwards until that entry is written again.
- R2: A read of entry 0 always returns 0x00000000, also during a write aimed at it.
- R3: A read of entry 1 always returns 0x00000001, also during a write aimed at it.
- R4: A write with enable high and address 0 or 1 changes no entry, and wr_illegal_o bit p (bit p belongs to write port p) is high in that same cycle.
- R5: wr_illegal_o bit p is low whenever port p is disabled or addresses entry 2..127.
- R6: When both write ports are enabled with the same address in 2..127, the data of port 1 is stored.
- R7: A read whose address equals an enabled, legal write address in the same cycle returns that write's data combinationally; if both ports write it, port 1's data is returned.
- R8: While rst_ni is low, entries 2..127 are zero; they stay zero after release until written.
- R9: The four read ports are independent: each returns its own address's value in the same cycle, duplicates allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | 4x7 | Read addresses, one per read port |
| rd_data_o | output | 4x32 | Read data, combinational from rd_addr_i |
| wr_en_i | input | 2 | Write enables, one per write port |
| wr_addr_i | input | 2x7 | Write addresses |
| wr_data_i | input | 2x32 | Write data |
| wr_illegal_o | output | 2 | Per-port flag: write aimed at entry 0 or 1 |

## Verification
The functions that meet in one cycle are write-port arbitration and read bypass: both write ports hit the same entry while one or more read ports read that entry. The bench provokes this by drawing random addresses mostly from a small window around the constant entries, plus directed cycles with an exact collision, and judges each read against a bench model that applies port 1 over port 0 for both the bypass value and the value stored at the edge. Writes to the constant entries overlapping reads of those same entries are judged the same way, expecting the constant and the per-port flag.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_ZERO_IDX = 0;
  localparam int unsigned RF_ONE_IDX  = 1;
  localparam int unsigned RF_NUM_CONST = 2;
endpackage

// File: rtl/rf_wr_select.sv
module rf_wr_select
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 128,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_WR   = 2,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic [NUM_WR-1:0]              wr_en_i,
  input  logic [NUM_WR-1:0][AW-1:0]      wr_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i,
  output logic [NUM_REGS-1:0]            ent_we_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0] ent_wd_o,
  output logic [NUM_WR-1:0]              illegal_o
);
  for (genvar p = 0; p < NUM_WR; p++) begin : g_ill
    assign illegal_o[p] = wr_en_i[p] && (wr_addr_i[p] < AW'(RF_NUM_CONST));
  end

  for (genvar e = 0; e < NUM_REGS; e++) begin : g_ent
    if (e < RF_NUM_CONST) begin : g_const
      assign ent_we_o[e] = 1'b0;
      assign ent_wd_o[e] = '0;
    end else begin : g_store
      // later ports override earlier ones
      always_comb begin
        ent_we_o[e] = 1'b0;
        ent_wd_o[e] = '0;
        for (int p = 0; p < NUM_WR; p++) begin
          if (wr_en_i[p] && wr_addr_i[p] == AW'(e)) begin
            ent_we_o[e] = 1'b1;
            ent_wd_o[e] = wr_data_i[p];
          end
        end
      end
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 128,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_REGS-1:0]             ent_we_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] ent_wd_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] mem_q_o
);
  for (genvar e = 0; e < NUM_REGS; e++) begin : g_ent
    if (e == RF_ZERO_IDX) begin : g_zero
      logic unused_w;
      assign unused_w   = ^{ent_we_i[e], ent_wd_i[e]};
      assign mem_q_o[e] = '0;
    end else if (e == RF_ONE_IDX) begin : g_one
      logic unused_w;
      assign unused_w   = ^{ent_we_i[e], ent_wd_i[e]};
      assign mem_q_o[e] = DATA_W'(1);
    end else begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          mem_q_o[e] <= '0;
        else if (ent_we_i[e]) mem_q_o[e] <= ent_wd_i[e];
      end
    end
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int unsigned NUM_REGS = 128,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic [AW-1:0]                   rd_addr_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q_i,
  input  logic [NUM_REGS-1:0]             ent_we_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] ent_wd_i,
  output logic [DATA_W-1:0]               rd_data_o
);
  // same-cycle bypass; constant entries never flag a write
  assign rd_data_o = ent_we_i[rd_addr_i] ? ent_wd_i[rd_addr_i] : mem_q_i[rd_addr_i];
endmodule

// File: rtl/rf_const_regfile.sv
module rf_const_regfile #(
  parameter int unsigned NUM_REGS = 128,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_RD   = 4,
  parameter int unsigned NUM_WR   = 2,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_RD-1:0][AW-1:0]      rd_addr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o,
  input  logic [NUM_WR-1:0]              wr_en_i,
  input  logic [NUM_WR-1:0][AW-1:0]      wr_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i,
  output logic [NUM_WR-1:0]              wr_illegal_o
);
  logic [NUM_REGS-1:0]             ent_we;
  logic [NUM_REGS-1:0][DATA_W-1:0] ent_wd;
  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

  rf_wr_select #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_WR(NUM_WR)) u_wsel (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ent_we_o  (ent_we),
    .ent_wd_o  (ent_wd),
    .illegal_o (wr_illegal_o)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ent_we_i (ent_we),
    .ent_wd_i (ent_wd),
    .mem_q_o  (mem_q)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
      .rd_addr_i (rd_addr_i[r]),
      .mem_q_i   (mem_q),
      .ent_we_i  (ent_we),
      .ent_wd_i  (ent_wd),
      .rd_data_o (rd_data_o[r])
    );

    p_const_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_addr_i[r] == '0 |-> rd_data_o[r] == '0);
    p_const_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_addr_i[r] == AW'(1) |-> rd_data_o[r] == DATA_W'(1));
    p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[NUM_WR-1] && wr_addr_i[NUM_WR-1] > AW'(1) && rd_addr_i[r] == wr_addr_i[NUM_WR-1])
      |-> rd_data_o[r] == wr_data_i[NUM_WR-1]);
  end

  for (genvar p = 0; p < NUM_WR; p++) begin : g_chk_wr
    p_flag_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[p] && wr_addr_i[p] <= AW'(1)) |-> wr_illegal_o[p]);
    p_flag_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i[p] || wr_addr_i[p] > AW'(1)) |-> !wr_illegal_o[p]);
  end

  p_port_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[0] && wr_en_i[NUM_WR-1] && wr_addr_i[0] == wr_addr_i[NUM_WR-1] && wr_addr_i[0] > AW'(1))
    |=> mem_q[$past(wr_addr_i[NUM_WR-1])] == $past(wr_data_i[NUM_WR-1]));
endmodule

// File: tb/sim_rf_const_regfile.sv
`timescale 1ns/1ps
module sim_rf_const_regfile;
  localparam int unsigned NREG = 128;
  localparam int unsigned DW   = 32;
  localparam int unsigned NRD  = 4;
  localparam int unsigned NWR  = 2;
  localparam int unsigned AW   = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NRD-1:0][AW-1:0] rd_addr = '0;
  logic [NRD-1:0][DW-1:0] rd_data;
  logic [NWR-1:0]         wr_en = '0;
  logic [NWR-1:0][AW-1:0] wr_addr = '0;
  logic [NWR-1:0][DW-1:0] wr_data = '0;
  logic [NWR-1:0]         wr_ill;

  always #2.5 clk = ~clk;

  rf_const_regfile u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_illegal_o(wr_ill)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NREG];

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    if (a == 0) return '0;
    if (a == 1) return 32'd1;
    if (!rst_ni) return '0;
    if (wr_en[1] && wr_addr[1] == a) return wr_data[1];
    if (wr_en[0] && wr_addr[0] == a) return wr_data[0];
    return model[a];
  endfunction

  function automatic string tag_for(input logic [AW-1:0] a);
    if (a == 0) return "R2";
    if (a == 1) return "R3";
    if ((wr_en[1] && wr_addr[1] == a) || (wr_en[0] && wr_addr[0] == a)) return "R7";
    return "R1/R9";
  endfunction

  // called just after a negedge with inputs set; returns at next negedge
  task automatic step();
    #1;
    for (int r = 0; r < NRD; r++) chk(tag_for(rd_addr[r]), rd_data[r], exp_read(rd_addr[r]));
    for (int p = 0; p < NWR; p++) begin
      logic e;
      e = wr_en[p] && (wr_addr[p] < 2);
      chk(e ? "R4" : "R5", {31'd0, wr_ill[p]}, {31'd0, e});
    end
    @(posedge clk);
    if (rst_ni)
      for (int p = 0; p < NWR; p++)
        if (wr_en[p] && wr_addr[p] >= 2) model[wr_addr[p]] = wr_data[p];
    @(negedge clk);
  endtask

  task automatic idle_writes();
    wr_en = '0;
  endtask

  task automatic sweep_all();
    idle_writes();
    for (int b = 0; b < NREG / NRD; b++) begin
      for (int r = 0; r < NRD; r++) rd_addr[r] = AW'(b * NRD + r);
      step();
    end
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    if ($urandom_range(0, 3) != 0) return AW'($urandom_range(0, 7));
    return AW'($urandom_range(0, NREG - 1));
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5813));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R8: reads while in reset
    rd_addr = {7'd2, 7'd127, 7'd1, 7'd0};
    step();
    rst_ni = 1'b1;
    @(negedge clk);
    sweep_all(); // R8 zero after release

    // R4/R2/R3: writes to constant entries, read same cycle
    wr_en = 2'b11; wr_addr = {7'd1, 7'd0}; wr_data = {32'hDEAD_BEEF, 32'hFFFF_FFFF};
    rd_addr = {7'd1, 7'd0, 7'd1, 7'd0};
    step();
    idle_writes(); step();

    // R6/R7: collision on same entry with bypass reads
    wr_en = 2'b11; wr_addr = {7'd9, 7'd9}; wr_data = {32'h1111_2222, 32'h3333_4444};
    rd_addr = {7'd9, 7'd9, 7'd0, 7'd9};
    step();
    idle_writes(); rd_addr = {7'd9, 7'd9, 7'd9, 7'd9};
    step(); // R6 stored value is port 1's
    // one legal, one illegal in same cycle
    wr_en = 2'b11; wr_addr = {7'd0, 7'd127}; wr_data = {32'hAAAA_5555, 32'h0BAD_F00D};
    rd_addr = {7'd127, 7'd0, 7'd1, 7'd127};
    step();
    idle_writes(); step();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < NWR; p++) begin
        wr_en[p]   = ($urandom_range(0, 3) != 0);
        wr_addr[p] = rnd_addr();
        wr_data[p] = $urandom();
      end
      if ($urandom_range(0, 7) == 0) wr_addr[1] = wr_addr[0];
      for (int r = 0; r < NRD; r++)
        rd_addr[r] = ($urandom_range(0, 1) == 0) ? wr_addr[$urandom_range(0, 1)] : rnd_addr();
      step();
    end
    sweep_all(); // R1 full readback

    // R8: reset mid-run clears storage
    idle_writes();
    rst_ni = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    rd_addr = {7'd3, 7'd5, 7'd9, 7'd127};
    step();
    rst_ni = 1'b1;
    @(negedge clk);
    sweep_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule